// File: doc/BRIEF.md
# Halfword Fetch Realigner

This block sits between a fetch port that returns one aligned 32-bit word per handshake and an instruction decoder. It breaks each word into two halfwords and keeps them in a small queue. It then hands the decoder whole instructions, one at a time. An instruction is one halfword or two. The block decides which from the two lowest bits of the leading halfword alone. Instructions may start on any even address, so a 32-bit instruction can begin in the upper half of one fetch word and end in the lower half of the next.

While the second word of such an instruction is outstanding, its low half waits at the head of the queue and acts as the straddle holder. When the second word arrives, the two halves leave together. The result carries the start pc, and its fault flag is set if either contributing fetch was reported faulty.

A redirect input replaces the pc, empties the queue, and restarts fetch at the word that contains the new target. If the target is the upper half of a word, the lower half of the first returned word is thrown away.

Top module: `hw_fetch_align`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is low and `fetch_addr` equals the word address of `RESET_PC`.
- R2: A leading halfword whose bits [1:0] equal 2'b11 starts a 32-bit instruction. Any other value starts a 16-bit instruction. A 16-bit instruction is presented with `out_compressed`=1 and with `out_inst[31:16]` zero. A 32-bit instruction is presented as {second halfword, first halfword} with `out_compressed`=0.
- R3: After an instruction is accepted, the pc of the next instruction is the old pc plus 2 for a 16-bit instruction and plus 4 for a 32-bit instruction.
- R4: A 32-bit instruction that starts in the upper half of a fetch word is held until the next word arrives. It is then delivered whole, with its low half taken from bits [31:16] of the first word and its high half from bits [15:0] of the second word.
- R5: `out_fault` is set when any halfword of the delivered instruction came from a fetch with `fetch_fault` high, including a faulty second word of a straddling instruction. `out_pc` is always the address of the first halfword.
- R6: In a cycle with `redirect_valid` high, `out_valid` is low. All buffered halfwords, including a held straddle half, are discarded. The next `out_pc` is `redirect_pc`, and fetch resumes at {`redirect_pc`[AW-1:2], 2'b00}. Redirect targets are even.
- R7: When `redirect_pc`[1] is 1, the first word fetched after the redirect supplies only its upper halfword.
- R8: While `out_valid` is high and `out_ready` is low, and no redirect arrives, `out_valid`, `out_inst` and `out_pc` stay unchanged in the next cycle. Every instruction is delivered exactly once and in address order.
- R9: `fetch_ready` is low while `redirect_valid` is high. It is also low while fewer than two halfword slots of the queue are free.
- R10: Each word accepted through the `fetch_valid`/`fetch_ready` handshake advances `fetch_addr` by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redirect_valid | input | 1 | Take a new pc this cycle and flush |
| redirect_pc | input | AW | New pc (even) |
| fetch_addr | output | AW | Word-aligned address of the word wanted next |
| fetch_valid | input | 1 | Fetch word available for `fetch_addr` |
| fetch_ready | output | 1 | Block accepts the fetch word this cycle |
| fetch_data | input | 32 | Fetched word, lower halfword at the lower address |
| fetch_fault | input | 1 | The fetch of this word faulted |
| out_valid | output | 1 | A whole instruction is presented |
| out_ready | input | 1 | Decoder takes the presented instruction |
| out_inst | output | 32 | Instruction bits |
| out_pc | output | AW | Address of the instruction's first halfword |
| out_compressed | output | 1 | Instruction is 16 bits |
| out_fault | output | 1 | A fetch supplying this instruction faulted |

## Verification
The bench builds the block with AW=16, QDEPTH=4 and RESET_PC=16'h1000. The 16-bit address space lets random redirects reach every word-offset combination, and lets a modelled memory place fixed straddling and faulting words at known addresses. A queue depth of four halfwords fills after two words with the decoder stalled. This makes the back-pressure on `fetch_ready`, and a flush of a full queue, easy to reach in a few cycles.

// File: rtl/hwfa_pkg.sv
package hwfa_pkg;

  typedef struct packed {
    logic [15:0] bits;
    logic        flt;
  } half_t;

  // leading halfword says whether the instruction spans two halfwords
  function automatic logic half_is_wide(input logic [15:0] h);
    return h[1:0] == 2'b11;
  endfunction

  // byte step to the next sequential instruction
  function automatic logic [2:0] pc_step(input logic wide);
    return wide ? 3'd4 : 3'd2;
  endfunction

  // number of halfwords an instruction occupies in the queue
  function automatic logic [1:0] half_count(input logic wide);
    return wide ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/hwfa_queue.sv
module hwfa_queue
  import hwfa_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic [1:0]      push_n,
  input  half_t [1:0]     push_h,
  input  logic [1:0]      pop_n,
  output half_t           head0,
  output half_t           head1,
  output logic [CW-1:0]   count,
  output logic            free_two
);

  half_t         q  [DEPTH];
  half_t         s1 [DEPTH];
  half_t         s2 [DEPTH];
  half_t         nq [DEPTH];
  logic [CW-1:0] cnt;
  logic [CW-1:0] base;
  logic [CW-1:0] cnt_next;

  // drop popped entries by shifting one slot per popped halfword
  always_comb begin
    for (int i = 0; i < DEPTH - 1; i++) s1[i] = (pop_n != 2'd0) ? q[i + 1] : q[i];
    s1[DEPTH-1] = (pop_n != 2'd0) ? '0 : q[DEPTH-1];
    for (int i = 0; i < DEPTH - 1; i++) s2[i] = (pop_n == 2'd2) ? s1[i + 1] : s1[i];
    s2[DEPTH-1] = (pop_n == 2'd2) ? '0 : s1[DEPTH-1];
  end

  // append pushed halfwords behind the survivors
  always_comb begin
    base     = cnt - CW'(pop_n);
    cnt_next = base + CW'(push_n);
    for (int i = 0; i < DEPTH; i++) begin
      nq[i] = s2[i];
      if (push_n != 2'd0 && CW'(i) == base)         nq[i] = push_h[0];
      if (push_n == 2'd2 && CW'(i) == base + CW'(1)) nq[i] = push_h[1];
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (!rst_n || flush) q[g] <= '0;
        else                 q[g] <= nq[g];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || flush) cnt <= '0;
    else                 cnt <= cnt_next;
  end

  assign head0    = q[0];
  assign head1    = q[1];
  assign count    = cnt;
  assign free_two = cnt <= CW'(DEPTH - 2);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush) |-> (int'(cnt) - int'(pop_n) + int'(push_n) <= DEPTH));

  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pop_n) <= int'(cnt));

endmodule

// File: rtl/hwfa_lenpick.sv
module hwfa_lenpick
  import hwfa_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  half_t          head0,
  input  half_t          head1,
  input  logic [CW-1:0]  count,
  output logic           avail,
  output logic           wide,
  output logic           straddle_wait,
  output logic [31:0]    inst,
  output logic           fault
);

  logic have_one;
  logic have_two;

  assign have_one      = count >= CW'(1);
  assign have_two      = count >= CW'(2);
  assign wide          = half_is_wide(head0.bits);
  assign avail         = have_one && (!wide || have_two);
  assign straddle_wait = have_one && wide && !have_two;

  always_comb begin
    if (wide) begin
      inst  = {head1.bits, head0.bits};
      fault = head0.flt | head1.flt;
    end else begin
      inst  = {16'h0000, head0.bits};
      fault = head0.flt;
    end
  end

endmodule

// File: rtl/hwfa_fetchptr.sv
module hwfa_fetchptr #(
  parameter int AW = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redirect_valid,
  input  logic [AW-1:0] redirect_pc,
  input  logic          accept,
  output logic [AW-1:0] fetch_addr,
  output logic          drop_low
);

  function automatic logic [AW-1:0] word_of(input logic [AW-1:0] a);
    return {a[AW-1:2], 2'b00};
  endfunction

  logic [AW-1:0] faddr;
  logic          drop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      faddr <= word_of(RESET_PC);
      drop  <= RESET_PC[1];
    end else if (redirect_valid) begin
      faddr <= word_of(redirect_pc);
      drop  <= redirect_pc[1];
    end else if (accept) begin
      faddr <= faddr + AW'(4);
      drop  <= 1'b0;
    end
  end

  assign fetch_addr = faddr;
  assign drop_low   = drop;

  assert_word_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !redirect_valid) |=> (fetch_addr == $past(fetch_addr) + AW'(4)));

  assert_restart_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (fetch_addr[1:0] == 2'b00 &&
                        fetch_addr[AW-1:2] == $past(redirect_pc[AW-1:2])));

  assert_even_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> !redirect_pc[0]);

endmodule

// File: rtl/hw_fetch_align.sv
module hw_fetch_align
  import hwfa_pkg::*;
#(
  parameter int AW = 32,
  parameter int QDEPTH = 4,
  parameter logic [AW-1:0] RESET_PC = '0,
  localparam int CW = $clog2(QDEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redirect_valid,
  input  logic [AW-1:0] redirect_pc,
  output logic [AW-1:0] fetch_addr,
  input  logic          fetch_valid,
  output logic          fetch_ready,
  input  logic [31:0]   fetch_data,
  input  logic          fetch_fault,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [31:0]   out_inst,
  output logic [AW-1:0] out_pc,
  output logic          out_compressed,
  output logic          out_fault
);

  // named internal events
  logic          accept;
  logic          fire;
  logic          drop_low;
  logic          free_two;
  logic          avail;
  logic          wide;
  logic          straddle_wait;
  logic [CW-1:0] q_count;
  logic [1:0]    push_n;
  logic [1:0]    pop_n;
  half_t [1:0]   push_h;
  half_t         head0;
  half_t         head1;
  logic [AW-1:0] head_pc;

  hwfa_fetchptr #(.AW(AW), .RESET_PC(RESET_PC)) u_ptr (
    .clk            (clk),
    .rst_n          (rst_n),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .accept         (accept),
    .fetch_addr     (fetch_addr),
    .drop_low       (drop_low)
  );

  assign fetch_ready = !redirect_valid && free_two;
  assign accept      = fetch_valid && fetch_ready;

  always_comb begin
    push_n = accept ? (drop_low ? 2'd1 : 2'd2) : 2'd0;
    push_h[0].bits = drop_low ? fetch_data[31:16] : fetch_data[15:0];
    push_h[0].flt  = fetch_fault;
    push_h[1].bits = fetch_data[31:16];
    push_h[1].flt  = fetch_fault;
  end

  hwfa_queue #(.DEPTH(QDEPTH)) u_q (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (redirect_valid),
    .push_n   (push_n),
    .push_h   (push_h),
    .pop_n    (pop_n),
    .head0    (head0),
    .head1    (head1),
    .count    (q_count),
    .free_two (free_two)
  );

  hwfa_lenpick #(.DEPTH(QDEPTH)) u_len (
    .head0         (head0),
    .head1         (head1),
    .count         (q_count),
    .avail         (avail),
    .wide          (wide),
    .straddle_wait (straddle_wait),
    .inst          (out_inst),
    .fault         (out_fault)
  );

  assign out_valid      = avail && !redirect_valid;
  assign out_compressed = !wide;
  assign fire           = out_valid && out_ready;
  assign pop_n          = fire ? half_count(wide) : 2'd0;

  always_ff @(posedge clk) begin
    if (!rst_n)              head_pc <= RESET_PC;
    else if (redirect_valid) head_pc <= redirect_pc;
    else if (fire)           head_pc <= head_pc + AW'(pc_step(wide));
  end

  assign out_pc = head_pc;

  assert_step_short_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_compressed) |=> (out_pc == $past(out_pc) + AW'(2)));

  assert_step_long_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !out_compressed) |=> (out_pc == $past(out_pc) + AW'(4)));

  assert_short_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_compressed) |-> (out_inst[31:16] == 16'h0000));

  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) ##1 !redirect_valid |->
      (out_valid && $stable(out_inst) && $stable(out_pc)));

  assert_flush_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> !out_valid);

  assert_redirect_pc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> (out_pc == $past(redirect_pc)));

  assert_no_fetch_on_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> !fetch_ready);

  assert_straddle_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (straddle_wait && !redirect_valid && !accept) |=> straddle_wait);

endmodule

// File: tb/sim_hw_fetch_align.sv
module sim_hw_fetch_align;

  localparam int AW = 16;
  localparam logic [15:0] RST_PC = 16'h1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        redirect_valid = 1'b0;
  logic [15:0] redirect_pc = '0;
  logic [15:0] fetch_addr;
  logic        fetch_valid = 1'b0;
  logic        fetch_ready;
  logic [31:0] fetch_data;
  logic        fetch_fault;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_inst;
  logic [15:0] out_pc;
  logic        out_compressed;
  logic        out_fault;

  always #2 clk = ~clk;

  hw_fetch_align #(.AW(AW), .QDEPTH(4), .RESET_PC(RST_PC)) u0 (
    .clk(clk), .rst_n(rst_n),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .fetch_addr(fetch_addr), .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .fetch_data(fetch_data), .fetch_fault(fetch_fault),
    .out_valid(out_valid), .out_ready(out_ready), .out_inst(out_inst),
    .out_pc(out_pc), .out_compressed(out_compressed), .out_fault(out_fault)
  );

  // memory model: fixed words at a few addresses, hashed content elsewhere
  function automatic logic [31:0] mem_word(input logic [15:0] a);
    logic [31:0] h;
    case ({a[15:2], 2'b00})
      16'hE000: return {16'hAB03, 16'h1111};
      16'hE004: return {16'h2222, 16'hCDEF};
      16'hE008: return {16'h5678, 16'h1237};
      16'hF000: return {16'h0007, 16'h0001};
      default: begin
        h = {16'h0, a[15:2], 2'b00} * 32'h045D9F3B;
        h = h ^ (h >> 15);
        h = h * 32'h2C1B3C6D;
        h = h ^ (h >> 12);
        return h;
      end
    endcase
  endfunction

  function automatic logic is_flt(input logic [15:0] a);
    return (a[15:8] == 8'hF0) && a[2];
  endfunction

  function automatic logic [15:0] half_at(input logic [15:0] a);
    logic [31:0] w;
    w = mem_word(a);
    return a[1] ? w[31:16] : w[15:0];
  endfunction

  always_comb begin
    fetch_data  = mem_word(fetch_addr);
    fetch_fault = is_flt(fetch_addr);
  end

  int nchk = 0;
  int nfail = 0;
  int ncyc = 0;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference state
  logic [15:0] exp_pc = RST_PC;
  logic [15:0] exp_faddr = {RST_PC[15:2], 2'b00};
  logic        p_valid = 1'b0;
  logic        p_ready = 1'b0;
  logic        p_rv = 1'b0;
  logic [31:0] p_inst = '0;
  logic [15:0] p_pc = '0;

  logic [31:0] log_inst [8];
  logic [15:0] log_pc   [8];
  logic        log_c    [8];
  logic        log_f    [8];
  int          log_n = 0;

  task automatic cycle(input logic fv, input logic ordy, input logic rv,
                       input logic [15:0] rpc);
    logic [15:0] h0;
    logic [15:0] h1;
    logic        w;
    logic [31:0] ei;
    logic        ef;
    @(negedge clk);
    fetch_valid = fv; out_ready = ordy; redirect_valid = rv; redirect_pc = rpc;
    #1;
    ncyc++;
    chk(fetch_addr == exp_faddr, "R10", "fetch_addr", {16'h0, fetch_addr}, {16'h0, exp_faddr});
    if (rv) begin
      chk(!fetch_ready, "R9", "fetch_ready during redirect", {31'h0, fetch_ready}, 32'h0);
      chk(!out_valid, "R6", "out_valid during redirect", {31'h0, out_valid}, 32'h0);
    end
    if (p_valid && !p_ready && !p_rv && !rv) begin
      chk(out_valid && out_inst == p_inst && out_pc == p_pc, "R8", "stall hold",
          {out_pc, out_inst[15:0]}, {p_pc, p_inst[15:0]});
    end
    if (out_valid && ordy) begin
      h0 = half_at(exp_pc);
      h1 = half_at(exp_pc + 16'd2);
      w  = (h0[1:0] == 2'b11);
      ei = w ? {h1, h0} : {16'h0, h0};
      ef = w ? (is_flt(exp_pc) | is_flt(exp_pc + 16'd2)) : is_flt(exp_pc);
      chk(out_pc == exp_pc, "R3", "out_pc", {16'h0, out_pc}, {16'h0, exp_pc});
      chk(out_inst == ei, "R2", "out_inst", out_inst, ei);
      chk(out_compressed == !w, "R2", "out_compressed", {31'h0, out_compressed}, {31'h0, !w});
      chk(out_fault == ef, "R5", "out_fault", {31'h0, out_fault}, {31'h0, ef});
      if (log_n < 8) begin
        log_inst[log_n] = out_inst; log_pc[log_n] = out_pc;
        log_c[log_n] = out_compressed; log_f[log_n] = out_fault;
        log_n++;
      end
      exp_pc = exp_pc + (w ? 16'd4 : 16'd2);
    end
    if (rv) begin
      exp_pc = rpc;
      exp_faddr = {rpc[15:2], 2'b00};
    end else if (fv && fetch_ready) begin
      exp_faddr = exp_faddr + 16'd4;
    end
    p_valid = out_valid; p_ready = ordy; p_rv = rv; p_inst = out_inst; p_pc = out_pc;
  endtask

  task automatic jump(input logic [15:0] tgt);
    cycle(1'b1, 1'b1, 1'b1, tgt);
    log_n = 0;
  endtask

  task automatic run_until(input int n);
    for (int i = 0; i < 40 && log_n < n; i++) cycle(1'b1, 1'b1, 1'b0, 16'h0);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    nfail++;
    nchk++;
    $display("FAIL R8 watchdog: cycles %0d expected below %0d", 100000, 100000);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk(!out_valid, "R1", "out_valid in reset", {31'h0, out_valid}, 32'h0);
    end
    chk(fetch_addr == 16'h1000, "R1", "fetch_addr in reset", {16'h0, fetch_addr}, 32'h1000);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(!out_valid, "R1", "out_valid after reset", {31'h0, out_valid}, 32'h0);

    // R7 and R4: odd-half target that straddles into the next word
    jump(16'hE002);
    run_until(2);
    chk(log_pc[0] == 16'hE002, "R7", "first pc after odd redirect", {16'h0, log_pc[0]}, 32'hE002);
    chk(log_inst[0] == 32'hCDEFAB03, "R4", "straddle assembly", log_inst[0], 32'hCDEFAB03);
    chk(log_c[1] && log_inst[1] == 32'h0000_2222, "R2", "short after straddle", log_inst[1], 32'h2222);

    // R2: aligned mix of short and long
    jump(16'hE000);
    run_until(4);
    chk(log_inst[0] == 32'h0000_1111 && log_c[0], "R2", "short at word start", log_inst[0], 32'h1111);
    chk(log_inst[3] == 32'h56781237 && !log_c[3], "R2", "aligned long", log_inst[3], 32'h56781237);
    chk(log_pc[3] == 16'hE008, "R3", "pc after +2,+4,+2", {16'h0, log_pc[3]}, 32'hE008);

    // R5: second half of a straddling instruction from a faulting word
    jump(16'hF000);
    run_until(2);
    chk(!log_f[0], "R5", "clean short before fault", {31'h0, log_f[0]}, 32'h0);
    chk(log_f[1], "R5", "straddle fault flag", {31'h0, log_f[1]}, 32'h1);
    chk(log_pc[1] == 16'hF002, "R5", "fault pc is start", {16'h0, log_pc[1]}, 32'hF002);
    chk(log_inst[1][15:0] == 16'h0007, "R4", "faulty straddle low half", {16'h0, log_inst[1][15:0]}, 32'h0007);

    // R9 and R6: fill the queue with the decoder stalled, then flush
    jump(16'h1000);
    for (int i = 0; i < 8; i++) cycle(1'b1, 1'b0, 1'b0, 16'h0);
    chk(!fetch_ready, "R9", "fetch_ready with full queue", {31'h0, fetch_ready}, 32'h0);
    jump(16'hE008);
    cycle(1'b0, 1'b1, 1'b0, 16'h0);
    chk(!out_valid, "R6", "empty after flush", {31'h0, out_valid}, 32'h0);
    run_until(1);
    chk(log_pc[0] == 16'hE008 && log_inst[0] == 32'h56781237, "R6", "first after flush",
        log_inst[0], 32'h56781237);

    // random traffic against the reference stream
    for (int i = 0; i < 8000; i++) begin
      logic fv;
      logic ordy;
      logic rv;
      logic [15:0] tgt;
      fv   = ($urandom % 4) != 0;
      ordy = ($urandom % 3) != 0;
      rv   = ($urandom % 50) == 0;
      tgt  = 16'($urandom) & 16'hFFFE;
      cycle(fv, ordy, rv, tgt);
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule